// File: doc/BRIEF.md
# Six-digit scrolling display controller

This block drives a row of six multiplexed common-cathode seven-segment digits. It shows the digits 0 to 5 and moves them to the left over time. Only one digit position is enabled at any moment. A fast scan counter visits the positions from left to right so that all six appear lit together. A slow step sequencer sets which glyph each position shows.

A mode input picks one of two scroll patterns. In rotate mode the row turns as a ring: the leftmost digit leaves and comes back in at the right. In fill mode the digits leave to the left and blanks enter from the right until the whole row is dark. The digits then come back in from the right one at a time until the row reads 012345 again. A blank position is kept dark by leaving every select line high during its scan slot. Both timing periods are parameters, so a simulation can use short ones.

Top module: `marquee_digits`

## Requirements
- R1: While `rst` is high (synchronous, active high), `dsel_n` is 111111. After release the scan position and the step start at 0, so the first output is dsel_n=011111 and seg=1111110.
- R2: Scan position p (0 = leftmost, 5 = rightmost) drives only bit 5-p of `dsel_n` low. For example, 011111 selects the leftmost digit and 111110 the rightmost. At most one bit is low at a time.
- R3: `seg` is active high and ordered a..g from bit 6 down to bit 0. The glyph codes are 0=1111110, 1=0110000, 2=1101101, 3=1111001, 4=0110011 and 5=1011011.
- R4: The scan position moves to the next position once every SCAN_PERIOD clocks, going 0,1,..,5 and then back to 0.
- R5: A step timer wraps every STEP_PERIOD clocks. The step index advances on every second wrap, starting with the first wrap after reset, so each step lasts 2*STEP_PERIOD clocks.
- R6: In rotate mode (`fill_mode`=0) there are 6 steps. At step s, position p shows the glyph (p+s) mod 6, which gives the row sequence 012345, 123450, ..., 501234.
- R7: In fill mode (`fill_mode`=1) there are 12 steps. For steps s=0..6, position p shows p+s, or a blank when p+s>5, so step 6 is all blank. For steps s=7..11, with k=s-6, the rightmost k positions show 0..k-1 and the others are blank.
- R8: During the scan slot of a blank position, `dsel_n` is 111111 and `seg` is 0000000.
- R9: A change of `fill_mode` takes effect at the next clock edge and restarts the step at 0.
- R10: After the last step of the current mode (5 in rotate mode, 11 in fill mode), the next step is 0. The step never leaves the range of its mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fill_mode | input | 1 | 0 = rotate pattern, 1 = shift-out/fill-in pattern |
| seg | output | 7 | Segments a..g, active high, a on bit 6 |
| dsel_n | output | 6 | Active-low digit selects, bit 5 = leftmost |

## Verification
The assertions assume that `fill_mode` is synchronous to `clk` and stable between edges. They do not assume that it stays constant for any number of cycles, because the restart rule covers every change. The stimulus drives `fill_mode` and `rst` only on falling edges. It flips the mode at random instants, including in the middle of a step and in the same cycle as a step wrap, and it adds a few reset pulses mid-run. Short parameter values are used so that every step of both patterns, and every wrap of both patterns, is reached many times.

// File: rtl/marq_pkg.sv
package marq_pkg;

    localparam int NPOS        = 6;
    localparam int ROT_STATES  = NPOS;
    localparam int FILL_STATES = 2 * NPOS;

    typedef logic [2:0]        pos_t;
    typedef logic [3:0]        step_t;
    typedef logic [6:0]        seg_t;
    typedef logic [NPOS-1:0]   sel_t;
    typedef logic signed [5:0] sidx_t;

    typedef enum logic {
        MODE_ROTATE = 1'b0,
        MODE_FILL   = 1'b1
    } mode_e;

    typedef struct packed {
        mode_e mode;
        step_t step;
        pos_t  pos;
    } view_t;

    localparam pos_t POS_LAST = pos_t'(NPOS - 1);

    function automatic step_t last_step(mode_e m);
        return (m == MODE_FILL) ? step_t'(FILL_STATES - 1) : step_t'(ROT_STATES - 1);
    endfunction

    function automatic seg_t glyph(pos_t d);
        case (d)
            3'd0:    return 7'b1111110;
            3'd1:    return 7'b0110000;
            3'd2:    return 7'b1101101;
            3'd3:    return 7'b1111001;
            3'd4:    return 7'b0110011;
            3'd5:    return 7'b1011011;
            default: return 7'b0000000;
        endcase
    endfunction

    // Digit index shown at a position; out of 0..NPOS-1 means blank.
    function automatic sidx_t slot_index(mode_e m, pos_t p, step_t s);
        int v;
        v = int'(p) + int'(s);
        if (m == MODE_ROTATE) begin
            if (v >= NPOS) v = v - NPOS;
        end else if (int'(s) > NPOS) begin
            v = v - FILL_STATES;
        end
        return sidx_t'(v);
    endfunction

endpackage

// File: rtl/marq_tick.sv
module marq_tick #(
    parameter int PERIOD = 2
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int            W    = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [W-1:0]  LAST = W'(PERIOD - 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || cnt == LAST) cnt <= '0;
        else                    cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);
endmodule

// File: rtl/marq_scan.sv
module marq_scan
    import marq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    output pos_t pos
);
    always_ff @(posedge clk) begin
        if (rst)       pos <= '0;
        else if (tick) pos <= (pos == POS_LAST) ? '0 : pos + 3'd1;
    end

    // R4
    scan_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(pos));
    // R4
    scan_next_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> pos == (($past(pos) == POS_LAST) ? 3'd0 : 3'($past(pos) + 3'd1)));
endmodule

// File: rtl/marq_step.sv
module marq_step
    import marq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wrap,
    input  logic  fill_mode,
    output step_t step,
    output mode_e mode_q
);
    logic  half;
    logic  adv;
    mode_e mode_in;

    assign mode_in = mode_e'(fill_mode);
    assign adv     = wrap && !half;

    always_ff @(posedge clk) begin
        if (rst) begin
            half   <= 1'b0;
            step   <= '0;
            mode_q <= MODE_ROTATE;
        end else begin
            if (wrap) half <= !half;
            if (mode_in != mode_q) begin
                mode_q <= mode_in;
                step   <= '0;
            end else if (adv) begin
                step <= (step >= last_step(mode_q)) ? '0 : step + 4'd1;
            end
        end
    end

    // R10
    step_range_chk: assert property (@(posedge clk) disable iff (rst)
        step <= last_step(mode_q));
    // R9
    mode_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_in != mode_q) |=> (step == '0 && mode_q == $past(mode_in)));
    // R5
    step_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!wrap && mode_in == mode_q) |=> $stable(step));
endmodule

// File: rtl/marq_render.sv
module marq_render
    import marq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  view_t view,
    output seg_t  seg,
    output sel_t  dsel_n
);
    sidx_t idx;
    logic  blank;

    always_comb begin
        idx    = slot_index(view.mode, view.pos, view.step);
        blank  = (idx < 0) || (idx > sidx_t'(NPOS - 1));
        seg    = blank ? '0 : glyph(pos_t'(idx[2:0]));
        dsel_n = (rst || blank) ? '1 : ~(sel_t'(1) << (POS_LAST - view.pos));
    end

    // R2
    sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~dsel_n));
    // R8
    blank_dark_chk: assert property (@(posedge clk) disable iff (rst)
        (dsel_n == '1) |-> (seg == '0));
    // R1
    always @(posedge clk) begin
        if (rst) reset_dark_chk: assert (dsel_n == '1);
    end
endmodule

// File: rtl/marquee_digits.sv
module marquee_digits
    import marq_pkg::*;
#(
    parameter int SCAN_PERIOD = 25001,
    parameter int STEP_PERIOD = 5000001
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       fill_mode,
    output logic [6:0] seg,
    output logic [5:0] dsel_n
);
    logic  scan_tick;
    logic  step_wrap;
    pos_t  pos;
    step_t step;
    mode_e mode_q;
    view_t view;

    marq_tick #(.PERIOD(SCAN_PERIOD)) u_scan_div (
        .clk(clk), .rst(rst), .tick(scan_tick)
    );

    marq_tick #(.PERIOD(STEP_PERIOD)) u_step_div (
        .clk(clk), .rst(rst), .tick(step_wrap)
    );

    marq_scan u_scan (
        .clk(clk), .rst(rst), .tick(scan_tick), .pos(pos)
    );

    marq_step u_step (
        .clk(clk), .rst(rst), .wrap(step_wrap), .fill_mode(fill_mode),
        .step(step), .mode_q(mode_q)
    );

    assign view = '{mode: mode_q, step: step, pos: pos};

    marq_render u_render (
        .clk(clk), .rst(rst), .view(view), .seg(seg), .dsel_n(dsel_n)
    );
endmodule

// File: tb/marquee_digits_bench.sv
`timescale 1ns/1ps
module marquee_digits_bench;
    localparam int SP = 3;
    localparam int TP = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fill_mode = 1'b0;
    logic [6:0] seg;
    logic [5:0] dsel_n;

    int errors = 0;
    int checks = 0;
    bit auto_on = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    marquee_digits #(.SCAN_PERIOD(SP), .STEP_PERIOD(TP)) u_marquee_digits (
        .clk(clk), .rst(rst), .fill_mode(fill_mode), .seg(seg), .dsel_n(dsel_n)
    );

    // reference state built from the requirements
    int m_sc, m_tc, m_pos, m_step;
    bit m_half, m_mode;

    always @(posedge clk) begin
        if (rst) begin
            m_sc <= 0; m_tc <= 0; m_pos <= 0; m_step <= 0; m_half <= 0; m_mode <= 0;
        end else begin
            if (m_sc == SP-1) begin m_sc <= 0; m_pos <= (m_pos == 5) ? 0 : m_pos + 1; end
            else m_sc <= m_sc + 1;
            if (m_tc == TP-1) begin m_tc <= 0; m_half <= !m_half; end
            else m_tc <= m_tc + 1;
            if (fill_mode != m_mode) begin
                m_mode <= fill_mode; m_step <= 0;
            end else if (m_tc == TP-1 && !m_half) begin
                m_step <= (m_step >= (m_mode ? 11 : 5)) ? 0 : m_step + 1;
            end
        end
    end

    function automatic logic [6:0] exp_glyph(int d);
        case (d)
            0: return 7'b1111110;
            1: return 7'b0110000;
            2: return 7'b1101101;
            3: return 7'b1111001;
            4: return 7'b0110011;
            5: return 7'b1011011;
            default: return 7'b0000000;
        endcase
    endfunction

    function automatic int exp_digit(bit fill, int p, int s);
        int k;
        if (!fill) return (p + s) % 6;
        if (s <= 6) return (p + s < 6) ? p + s : -1;
        k = s - 6;
        return (p >= 6 - k) ? p - (6 - k) : -1;
    endfunction

    function automatic logic [5:0] exp_sel(int p, int d);
        logic [5:0] v;
        if (d < 0) return 6'b111111;
        v = 6'b111111;
        v[5 - p] = 1'b0;
        return v;
    endfunction

    task automatic check(string tag, logic [6:0] es, logic [5:0] ed);
        checks++;
        if (seg !== es || dsel_n !== ed) begin
            errors++;
            $display("FAIL %s: actual seg=%b dsel_n=%b expected seg=%b dsel_n=%b",
                     tag, seg, dsel_n, es, ed);
        end
    endtask

    task automatic check_model(string tag);
        int d;
        if (rst) begin
            checks++;
            if (dsel_n !== 6'b111111) begin
                errors++;
                $display("FAIL %s: actual dsel_n=%b expected dsel_n=111111", tag, dsel_n);
            end
        end else begin
            d = exp_digit(m_mode, m_pos, m_step);
            check(tag, exp_glyph(d), exp_sel(m_pos, d));
        end
    endtask

    always @(negedge clk) begin
        if (auto_on) begin
            if (rst) check_model("R1");
            else if (exp_digit(m_mode, m_pos, m_step) < 0) check_model("R8");
            else if (m_mode) check_model("R7");
            else check_model("R6");
        end
    end

    task automatic edges(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R5: watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; fill_mode = 1'b0;
        edges(3);
        check("R1", seg, 6'b111111);
        rst = 1'b0;
        #0.1;
        check("R1", 7'b1111110, 6'b011111);
        edges(3);   // after e3: position 1, step 0
        check("R4", 7'b0110000, 6'b101111);
        edges(1);   // after e4
        check("R3", 7'b0110000, 6'b101111);
        edges(1);   // after e5: first wrap, step 1, position 1 -> glyph 2
        check("R5", 7'b1101101, 6'b101111);
        edges(9);   // after e14: step 1, position 4 -> glyph 5
        check("R5", 7'b1011011, 6'b111101);
        edges(1);   // after e15: step 2, position 5 -> glyph 1
        check("R5", 7'b0110000, 6'b111110);
        check("R2", 7'b0110000, 6'b111110);

        // R9 mode switch restarts step
        fill_mode = 1'b1;
        edges(1);
        checks++;
        if (m_step != 0) begin errors++; $display("FAIL R9: actual step=%0d expected 0", m_step); end
        check_model("R9");

        auto_on = 1'b1;
        // R10: full fill cycle to wrap
        while (m_step != 11) edges(1);
        while (m_step != 0) edges(1);
        check_model("R10");
        while (m_step != 6) edges(1);
        check_model("R8");

        // constrained random phase
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if ($urandom_range(0, 199) == 0) fill_mode = !fill_mode;
            if ($urandom_range(0, 999) == 0) rst = 1'b1;
            else rst = 1'b0;
        end
        // R10 in rotate mode
        fill_mode = 1'b0;
        rst = 1'b0;
        edges(1);
        while (m_step != 5) edges(1);
        while (m_step != 0) edges(1);
        check_model("R10");
        auto_on = 1'b0;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule